// File: doc/BRIEF.md
# SMBus Register Slave Interface

This block is a slave-only target for a two-wire I2C/SMBus bus, built to sit in front of a small register file. The raw SCL and SDA levels are sampled in the system clock domain. START, repeated START and STOP conditions are decoded from the sampled lines. Bytes are shifted MSB first, and the block drives SDA only by pulling it low through an output enable. The system clock must be much faster than SCL, which runs at 400 kHz or less.

A host selects the block with an address byte. The upper nibble of that byte is fixed and two of its bits come from strap pins. It then sends a command byte that sets the register pointer. After that it either writes data bytes through the register port or turns the bus around with a repeated START to read them back. Word transfers put the low byte first. The pointer steps after every data byte, so word and block transfers share one path.

A command byte of 88h followed by STOP requests a reboot of the configuration engine. While that engine reports busy, the block refuses its own address. Register addresses outside the implemented range are refused.

Top module: `smb_reg_slave`

## Requirements
- R1: An address byte with bits [7:4] = 1010b, bits [3:2] equal to `addr_pins_i[1:0]`, any value in bit 1, and R/W in bit 0 (0 = write, 1 = read) is acknowledged by pulling SDA low during the ninth clock.
- R2: An address byte that does not match is not acknowledged. The block then ignores all bytes until the next START.
- R3: While `busy_i` is high, a matching address byte is not acknowledged.
- R4: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP is honoured anywhere in a transfer except in the same SCL high pulse as the START before it; such a STOP is ignored and the transfer continues.
- R5: A command byte below REG_COUNT is acknowledged and loads the register pointer. A command byte at or above REG_COUNT, other than 88h, is not acknowledged and ends the transfer. The pointer always stays below REG_COUNT.
- R6: Each data byte after a legal command is acknowledged and produces one single-cycle `reg_wr_o` pulse carrying the pointer and the byte. The pointer then steps by one and wraps from REG_COUNT-1 to 0. A write word is therefore low byte at the pointer and high byte at the pointer plus one. Writes continue across repeated STARTs.
- R7: After a repeated START and an address with R/W = 1, the block sends the byte at the pointer, MSB first, and steps the pointer. A master ACK makes it send the next byte. A master NACK makes it release SDA until the next START.
- R8: A command byte 88h is acknowledged. If STOP follows it directly, `reboot_o` pulses for one cycle right after the STOP. If a data byte follows it instead, that byte is not acknowledged and no reboot is requested.
- R9: SDA is only ever pulled low, and the pull changes only while the sampled SCL is low.
- R10: During and right after reset, `sda_oe_o`, `reg_wr_o` and `reboot_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| addr_pins_i | input | 2 | Strap bits compared against address bits [3:2] |
| busy_i | input | 1 | Configuration engine busy (reboot or non-volatile write) |
| reg_addr_o | output | PtrW (6) | Register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Read data at `reg_addr_o`, combinational |
| reboot_o | output | 1 | Single-cycle reboot request |

## Verification
The assertions assume a well-behaved master. It changes SDA while SCL is high only to make a START or STOP. It holds each SCL phase for far longer than the three-cycle synchronizer delay. It never attempts a STOP while the slave is pulling SDA low. The bench keeps within these assumptions: every SCL quarter period lasts 20 system clocks, and SDA moves only inside the low phase except in the condition tasks. The one deliberate exception to normal framing is a STOP placed in the same SCL high pulse as a START, which the block is required to ignore.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK
  } link_st_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_DATA
  } byte_kind_e;

  localparam logic [3:0] DEV_PREFIX  = 4'b1010;
  localparam logic [7:0] REBOOT_CODE = 8'h88;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= line_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;
    assign fall_o[g] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_lvl_i,
  input  logic scl_fall_i,
  input  logic sda_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  logic hold_q;  // SCL still high since the last START

  assign start_o = scl_lvl_i & sda_fall_i;
  assign stop_o  = scl_lvl_i & sda_rise_i & ~hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= 1'b0;
    else if (start_o)    hold_q <= 1'b1;
    else if (scl_fall_i) hold_q <= 1'b0;
  end

  AST_START_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (scl_lvl_i && $past(sda_lvl_i) && !sda_lvl_i)); // R4
  AST_STOP_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (scl_lvl_i && !$past(sda_lvl_i) && sda_lvl_i)); // R4
endmodule

// File: rtl/smb_ptr_ctl.sv
module smb_ptr_ctl #(
  parameter int REG_COUNT = 64,
  parameter int PtrW      = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PtrW-1:0] load_val_i,
  input  logic            inc_i,
  output logic [PtrW-1:0] ptr_o
);
  localparam logic [PtrW-1:0] LastIdx = PtrW'(REG_COUNT - 1);

  logic [PtrW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= (ptr_q == LastIdx) ? '0 : ptr_q + PtrW'(1);
  end

  assign ptr_o = ptr_q;

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ptr_q) < REG_COUNT)); // R5
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_pkg::*;
#(
  parameter int REG_COUNT = 64,
  parameter int PtrW      = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_lvl_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            sda_lvl_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [1:0]      addr_pins_i,
  input  logic            busy_i,
  input  logic [7:0]      rdata_i,
  output logic            sda_oe_o,
  output logic            ptr_load_o,
  output logic [PtrW-1:0] ptr_load_val_o,
  output logic            ptr_inc_o,
  output logic            wr_o,
  output logic [7:0]      wdata_o,
  output logic            reboot_o
);
  localparam logic [8:0] RegLim = 9'(REG_COUNT);

  link_st_e        state_q;
  byte_kind_e      kind_q;
  logic [3:0]      cnt_q;
  logic [7:0]      rx_sr_q, tx_sr_q;
  logic            oe_q, to_tx_q, rb_pend_q, mack_q;
  logic            wr_q, inc_q, load_q, reboot_q;
  logic [7:0]      wdata_q;
  logic [PtrW-1:0] load_val_q;

  logic addr_ok, cmd_legal, byte_done;
  assign addr_ok   = (rx_sr_q[7:4] == DEV_PREFIX) && (rx_sr_q[3:2] == addr_pins_i) && !busy_i;
  assign cmd_legal = {1'b0, rx_sr_q} < RegLim;
  assign byte_done = scl_fall_i && (cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= BK_ADDR;
      cnt_q      <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      oe_q       <= 1'b0;
      to_tx_q    <= 1'b0;
      rb_pend_q  <= 1'b0;
      mack_q     <= 1'b0;
      wr_q       <= 1'b0;
      inc_q      <= 1'b0;
      load_q     <= 1'b0;
      reboot_q   <= 1'b0;
      wdata_q    <= '0;
      load_val_q <= '0;
    end else begin
      wr_q     <= 1'b0;
      inc_q    <= 1'b0;
      load_q   <= 1'b0;
      reboot_q <= 1'b0;
      if (start_i) begin
        state_q   <= ST_RX;
        kind_q    <= BK_ADDR;
        cnt_q     <= '0;
        oe_q      <= 1'b0;
        rb_pend_q <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        oe_q      <= 1'b0;
        reboot_q  <= rb_pend_q;
        rb_pend_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i) begin
              rx_sr_q <= {rx_sr_q[6:0], sda_lvl_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (byte_done) begin
              cnt_q <= '0;
              unique case (kind_q)
                BK_ADDR: begin
                  if (addr_ok) begin
                    oe_q    <= 1'b1;
                    to_tx_q <= rx_sr_q[0];
                    kind_q  <= BK_CMD;
                    state_q <= ST_RACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                BK_CMD: begin
                  if (rx_sr_q == REBOOT_CODE) begin
                    oe_q      <= 1'b1;
                    rb_pend_q <= 1'b1;
                    to_tx_q   <= 1'b0;
                    kind_q    <= BK_DATA;
                    state_q   <= ST_RACK;
                  end else if (cmd_legal) begin
                    oe_q       <= 1'b1;
                    load_q     <= 1'b1;
                    load_val_q <= rx_sr_q[PtrW-1:0];
                    to_tx_q    <= 1'b0;
                    kind_q     <= BK_DATA;
                    state_q    <= ST_RACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                default: begin
                  if (rb_pend_q) begin
                    rb_pend_q <= 1'b0;
                    state_q   <= ST_IDLE;
                  end else begin
                    oe_q    <= 1'b1;
                    wr_q    <= 1'b1;
                    inc_q   <= 1'b1;
                    wdata_q <= rx_sr_q;
                    to_tx_q <= 1'b0;
                    state_q <= ST_RACK;
                  end
                end
              endcase
            end
          end
          ST_RACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (to_tx_q) begin
                tx_sr_q <= rdata_i;
                oe_q    <= ~rdata_i[7];
                state_q <= ST_TX;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (byte_done) begin
              oe_q    <= 1'b0;
              inc_q   <= 1'b1;
              state_q <= ST_MACK;
            end else if (scl_fall_i) begin
              tx_sr_q <= {tx_sr_q[6:0], 1'b0};
              oe_q    <= ~tx_sr_q[6];
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_lvl_i;
            end else if (scl_fall_i) begin
              cnt_q <= '0;
              if (mack_q) begin
                tx_sr_q <= rdata_i;
                oe_q    <= ~rdata_i[7];
                state_q <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o       = oe_q;
  assign ptr_load_o     = load_q;
  assign ptr_load_val_o = load_val_q;
  assign ptr_inc_o      = inc_q;
  assign wr_o           = wr_q;
  assign wdata_o        = wdata_q;
  assign reboot_o       = reboot_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_lvl_i); // R9
  AST_WR_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q); // R6
  AST_REBOOT_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_q |-> $past(stop_i)); // R8
  AST_NO_WR_IN_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX) |-> !wr_q); // R7
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter int  REG_COUNT = 64,
  localparam int PtrW      = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [1:0]      addr_pins_i,
  input  logic            busy_i,
  output logic [PtrW-1:0] reg_addr_o,
  output logic [7:0]      reg_wdata_o,
  output logic            reg_wr_o,
  input  logic [7:0]      reg_rdata_i,
  output logic            reboot_o
);
  logic [1:0] lvl, rise, fall;  // [1]=SCL, [0]=SDA
  logic start, stop;
  logic ptr_load, ptr_inc;
  logic [PtrW-1:0] ptr_load_val;

  smb_line_sync #(.N(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({scl_i, sda_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  smb_cond_det u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (lvl[1]),
    .scl_fall_i (fall[1]),
    .sda_lvl_i  (lvl[0]),
    .sda_rise_i (rise[0]),
    .sda_fall_i (fall[0]),
    .start_o    (start),
    .stop_o     (stop)
  );

  smb_link_fsm #(.REG_COUNT(REG_COUNT), .PtrW(PtrW)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .scl_lvl_i      (lvl[1]),
    .scl_rise_i     (rise[1]),
    .scl_fall_i     (fall[1]),
    .sda_lvl_i      (lvl[0]),
    .start_i        (start),
    .stop_i         (stop),
    .addr_pins_i    (addr_pins_i),
    .busy_i         (busy_i),
    .rdata_i        (reg_rdata_i),
    .sda_oe_o       (sda_oe_o),
    .ptr_load_o     (ptr_load),
    .ptr_load_val_o (ptr_load_val),
    .ptr_inc_o      (ptr_inc),
    .wr_o           (reg_wr_o),
    .wdata_o        (reg_wdata_o),
    .reboot_o       (reboot_o)
  );

  smb_ptr_ctl #(.REG_COUNT(REG_COUNT), .PtrW(PtrW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_load_val),
    .inc_i      (ptr_inc),
    .ptr_o      (reg_addr_o)
  );
endmodule

// File: tb/smb_reg_slave_tb_top.sv
module smb_reg_slave_tb_top;
  localparam int RC = 64;
  localparam int Q  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, m_low = 1'b0, busy = 1'b0;
  logic sda_oe, wr, rb;
  logic [5:0] raddr;
  logic [7:0] wdata, rdata;
  wire sda_bus = ~(m_low | sda_oe);
  logic [7:0] regs [RC];
  assign rdata = regs[raddr];

  smb_reg_slave #(.REG_COUNT(RC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_pins_i(2'b10), .busy_i(busy),
    .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_wr_o(wr),
    .reg_rdata_i(rdata), .reboot_o(rb)
  );

  int n_chk = 0, n_fail = 0, rb_cnt = 0;
  logic [13:0] exp_q[$];
  bit done = 1'b0;

  // register model and write scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RC; i++) regs[i] = 8'h00;
    end else begin
      if (rb) rb_cnt++;
      if (wr) begin
        logic [13:0] e;
        regs[raddr] = wdata;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R6 unexpected write actual %0h:%0h expected none", raddr, wdata);
        end else begin
          e = exp_q.pop_front();
          if (e != {raddr, wdata}) begin
            n_fail++;
            $display("FAIL R6 write actual %0h:%0h expected %0h:%0h", raddr, wdata, e[13:8], e[7:0]);
          end
        end
      end
    end
  end

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic exp_wr(input logic [5:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic do_start(); m_low = 0; q(); scl_m = 1; q(); m_low = 1; q(); scl_m = 0; q(); endtask
  task automatic do_stop();  m_low = 1; q(); scl_m = 1; q(); m_low = 0; q(); endtask

  task automatic wbit(input bit b); m_low = ~b; q(); scl_m = 1; q(); q(); scl_m = 0; q(); endtask
  task automatic rbit(output bit b); m_low = 0; q(); scl_m = 1; q(); b = sda_bus; q(); scl_m = 0; q(); endtask

  task automatic send(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic recv(output logic [7:0] d, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      rbit(b);
      d[i] = b;
    end
    wbit(~mack);
  endtask

  initial begin
    bit ack, b;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R10 sda_oe", sda_oe, 0);
    chk(wr == 0, "R10 reg_wr", wr, 0);
    chk(rb == 0, "R10 reboot", rb, 0);
    rst_n = 1;
    q();

    // write word, low byte first
    do_start();
    send(8'hA8, ack); chk(ack, "R1 addr ack", ack, 1);
    send(8'h10, ack); chk(ack, "R5 cmd ack", ack, 1);
    exp_wr(6'h10, 8'h34); send(8'h34, ack); chk(ack, "R6 data ack", ack, 1);
    exp_wr(6'h11, 8'h12); send(8'h12, ack); chk(ack, "R6 data ack", ack, 1);
    do_stop();

    // don't-care address bit, pointer wrap
    do_start();
    send(8'hAA, ack); chk(ack, "R1 dont-care bit ack", ack, 1);
    send(8'h3F, ack); chk(ack, "R5 cmd 3F ack", ack, 1);
    exp_wr(6'h3F, 8'h5A); send(8'h5A, ack);
    exp_wr(6'h00, 8'hC3); send(8'hC3, ack); chk(ack, "R6 wrap ack", ack, 1);
    // consecutive write after repeated START
    do_start();
    send(8'hA8, ack);
    send(8'h20, ack);
    exp_wr(6'h20, 8'h88); send(8'h88, ack); chk(ack, "R6 rs write ack", ack, 1);
    do_stop();

    // read word
    do_start();
    send(8'hA8, ack); send(8'h10, ack);
    do_start();
    send(8'hA9, ack); chk(ack, "R7 read addr ack", ack, 1);
    recv(d, 1); chk(d == 8'h34, "R7 low byte", d, 8'h34);
    recv(d, 0); chk(d == 8'h12, "R7 high byte", d, 8'h12);
    rbit(b); chk(b == 1, "R7 released after nack", b, 1);
    do_stop();

    // read across wrap
    do_start();
    send(8'hA8, ack); send(8'h3F, ack);
    do_start();
    send(8'hAB, ack);
    recv(d, 1); chk(d == 8'h5A, "R7 byte 3F", d, 8'h5A);
    recv(d, 0); chk(d == 8'hC3, "R7 wrapped byte 00", d, 8'hC3);
    do_stop();

    // wrong prefix and wrong pins
    do_start();
    send(8'hB8, ack); chk(!ack, "R2 wrong prefix nack", ack, 0);
    send(8'h10, ack); chk(!ack, "R2 ignored after nack", ack, 0);
    do_stop();
    do_start();
    send(8'hA0, ack); chk(!ack, "R2 wrong pins nack", ack, 0);
    do_stop();

    // illegal command
    do_start();
    send(8'hA8, ack); send(8'h50, ack); chk(!ack, "R5 illegal cmd nack", ack, 0);
    send(8'h11, ack); chk(!ack, "R5 abandoned", ack, 0);
    do_stop();

    // busy
    busy = 1;
    do_start();
    send(8'hA8, ack); chk(!ack, "R3 busy nack", ack, 0);
    do_stop();
    busy = 0;

    // reboot request
    do_start();
    send(8'hA8, ack); send(8'h88, ack); chk(ack, "R8 code ack", ack, 1);
    do_stop();
    q();
    chk(rb_cnt == 1, "R8 reboot pulse", rb_cnt, 1);
    do_start();
    send(8'hA8, ack); send(8'h88, ack);
    send(8'h01, ack); chk(!ack, "R8 data after code nack", ack, 0);
    do_stop();
    q();
    chk(rb_cnt == 1, "R8 no reboot", rb_cnt, 1);

    // STOP in the same high pulse as START is ignored
    m_low = 1; q(); m_low = 0; q(); scl_m = 0; q();
    send(8'hA8, ack); chk(ack, "R4 stop ignored", ack, 1);
    send(8'h05, ack);
    exp_wr(6'h05, 8'h99); send(8'h99, ack);
    do_stop();
    scl_m = 0; q();
    send(8'hA8, ack); chk(!ack, "R4 stop honoured", ack, 0);
    do_stop();

    q();
    chk(exp_q.size() == 0, "R6 writes pending", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule